// File: doc/BRIEF.md
# Split or Cascaded Capture Timer

This block is a 16-bit timer/counter built from two 8-bit halves. A 2-bit mode field selects how the halves work. In the split modes the halves run on their own. In the cascaded modes they join into one 16-bit register. Time counting is driven by a programmable 8-bit prescaler. Event counting is driven by rising edges on an external pin. Each mode has two capture registers sized to its counting width. A rising edge on a capture trigger copies the running count into the matching capture register.

Software reaches the block through a one-cycle register write strobe and a combinational read port. The write side carries the mode and enables, the prescaler reload, the two match bytes and a write-1-to-clear flag register. The read side returns the counts, captures, flags and control byte. Each counting element compares itself against its match value. When it reaches that value, the next advance wraps it to zero and raises a sticky interrupt flag. All pins are plain level or strobe signals; no port carries a data stream, so there is no back-pressure.

Top module: `capture_timer`

## Requirements
- R1: After a synchronous reset, every read address (0 to 7) returns 0, and irq_lo and irq_hi are low.
- R2: Let P be the prescaler reload. The prescaler starts at 0 and produces one tick every P+1 clocks while it runs. It runs while en_lo (control bit 2) is set and the mode is not 3. While it is stopped its phase returns to 0 and the counts hold.
- R3: In modes 0 and 1 the low half advances on each prescaler tick. From a value equal to match_lo (write address 2), an advance loads 0 instead and sets irq_lo.
- R4: In mode 0 the high half stays at 0 whatever the external pin does. In mode 1, while en_hi (control bit 3) is set, it counts rising edges of ext_evt. From a value equal to match_hi (write address 3), an advance loads 0 instead and sets irq_hi.
- R5: In mode 2 the halves form a 16-bit timer {high, low} that advances on prescaler ticks. From a value equal to {match_hi, match_lo}, an advance wraps it to 0 and sets irq_hi. irq_lo is never set in modes 2 and 3.
- R6: In mode 3 the 16-bit pair, enabled by en_lo, counts rising edges of ext_evt with the same wrap and flag rule as R5. Prescaler settings have no effect.
- R7: Each of ext_evt, cap_trig[0] and cap_trig[1] passes through two synchronising flops and a rising-edge detector. A level first sampled high at clock edge k acts at edge k+2.
- R8: A synchronised rising edge on cap_trig[i] loads {count high, count low} into capture i. The load happens at the edge given by R7. In the cycle before that edge, a read of capture i still returns the earlier value. A trigger held high captures only once.
- R9: The flags are sticky. Writing address 4 with bit 0 set clears irq_lo, and with bit 1 set clears irq_hi. A zero bit leaves its flag unchanged.
- R10: Writing the control byte (address 0, bits 1:0 mode) with a mode different from the current one clears both halves and the prescaler phase. Rewriting the same mode leaves the count unchanged.
- R11: Read map: 0 count low, 1 count high, 2/3 capture 0 low/high, 4/5 capture 1 low/high, 6 flags {bit1 irq_hi, bit0 irq_lo}, 7 control byte {bit3 en_hi, bit2 en_lo, bits1:0 mode}. Write map: 0 control, 1 reload, 2 match_lo, 3 match_hi, 4 flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Combinational read data |
| ext_evt | input | 1 | External event input, asynchronous |
| cap_trig | input | 2 | Capture trigger inputs, asynchronous |
| irq_lo | output | 1 | Low-half match flag |
| irq_hi | output | 1 | High-half or 16-bit match flag |

## Verification
A wrong prescaler phase or reload compare shows at the count read port after the first tick, P+1 clocks after enable. The bench sweeps reload, match and run length, so an off-by-one anywhere in the divide or wrap path changes the frozen count. A broken carry between the halves, or a wrong match compare, first appears at the high byte or the flag. This happens at the 256th low-half advance or at the wrap. A capture or synchroniser stage that is too early or too late shows at the read port within two cycles of the trigger edge.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT    = 2'd0,
    MODE_MIXED    = 2'd1,
    MODE_CASC_TMR = 2'd2,
    MODE_CASC_CNT = 2'd3
  } ctmr_mode_e;

  localparam int CTMR_ADDR_W = 3;
  localparam int CTMR_N_CAP  = 2;

  localparam logic [CTMR_ADDR_W-1:0] WA_CTRL   = 3'd0;
  localparam logic [CTMR_ADDR_W-1:0] WA_RELOAD = 3'd1;
  localparam logic [CTMR_ADDR_W-1:0] WA_MLO    = 3'd2;
  localparam logic [CTMR_ADDR_W-1:0] WA_MHI    = 3'd3;
  localparam logic [CTMR_ADDR_W-1:0] WA_FCLR   = 3'd4;

  localparam logic [CTMR_ADDR_W-1:0] RA_CNT_LO  = 3'd0;
  localparam logic [CTMR_ADDR_W-1:0] RA_CNT_HI  = 3'd1;
  localparam logic [CTMR_ADDR_W-1:0] RA_CAP0_LO = 3'd2;
  localparam logic [CTMR_ADDR_W-1:0] RA_CAP0_HI = 3'd3;
  localparam logic [CTMR_ADDR_W-1:0] RA_CAP1_LO = 3'd4;
  localparam logic [CTMR_ADDR_W-1:0] RA_CAP1_HI = 3'd5;
  localparam logic [CTMR_ADDR_W-1:0] RA_FLAGS   = 3'd6;
  localparam logic [CTMR_ADDR_W-1:0] RA_CTRL    = 3'd7;
endpackage

// File: rtl/ctmr_edge_sync.sv
module ctmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  localparam int SH_W = STAGES + 1;
  logic [SH_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SH_W-2:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/ctmr_prescaler.sv
module ctmr_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         clr,
  input  logic [W-1:0] reload,
  output logic         tick
);
  logic [W-1:0] phase;

  assign tick = run && (phase == reload);

  always_ff @(posedge clk) begin
    if (rst || clr || !run) phase <= '0;
    else if (tick)          phase <= '0;
    else                    phase <= phase + 1'b1;
  end
endmodule

// File: rtl/ctmr_half.sv
module ctmr_half #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  input  logic         wrap,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (step)  cnt <= wrap ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/ctmr_capture.sv
module ctmr_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         trig,
  input  logic [W-1:0] src,
  output logic [W-1:0] val
);
  always_ff @(posedge clk) begin
    if (rst)       val <= '0;
    else if (trig) val <= src;
  end
endmodule

// File: rtl/capture_timer.sv
module capture_timer
  import ctmr_pkg::*;
#(
  parameter int HALF_W      = 8,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [CTMR_ADDR_W-1:0] wr_addr,
  input  logic [HALF_W-1:0]      wr_data,
  input  logic [CTMR_ADDR_W-1:0] rd_addr,
  output logic [HALF_W-1:0]      rd_data,
  input  logic                   ext_evt,
  input  logic [CTMR_N_CAP-1:0]  cap_trig,
  output logic                   irq_lo,
  output logic                   irq_hi
);
  localparam int FULL_W = 2 * HALF_W;
  localparam logic [HALF_W-1:0] HALF_ONES = {HALF_W{1'b1}};

  ctmr_mode_e        mode_q;
  logic              en_lo_q, en_hi_q;
  logic [PRE_W-1:0]  reload_q;
  logic [HALF_W-1:0] mlo_q, mhi_q;

  logic [HALF_W-1:0] cnt_lo, cnt_hi;
  logic [CTMR_N_CAP-1:0][FULL_W-1:0] cap_val;
  logic [CTMR_N_CAP-1:0] cap_rise;
  logic ext_rise, tick;

  logic mode_chg, ctrl_wr, fclr_wr;
  logic cascaded, pre_run;
  logic lo_step, lo_wrap, hi_step, hi_wrap;
  logic full_hit, casc_ev;

  // ---------------- register writes ----------------
  assign ctrl_wr  = wr_en && (wr_addr == WA_CTRL);
  assign fclr_wr  = wr_en && (wr_addr == WA_FCLR);
  assign mode_chg = ctrl_wr && (ctmr_mode_e'(wr_data[1:0]) != mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_SPLIT;
      en_lo_q  <= 1'b0;
      en_hi_q  <= 1'b0;
      reload_q <= '0;
      mlo_q    <= HALF_ONES;
      mhi_q    <= HALF_ONES;
    end else if (wr_en) begin
      case (wr_addr)
        WA_CTRL: begin
          mode_q  <= ctmr_mode_e'(wr_data[1:0]);
          en_lo_q <= wr_data[2];
          en_hi_q <= wr_data[3];
        end
        WA_RELOAD: reload_q <= wr_data[PRE_W-1:0];
        WA_MLO:    mlo_q    <= wr_data;
        WA_MHI:    mhi_q    <= wr_data;
        default: ;
      endcase
    end
  end

  // ---------------- input conditioning ----------------
  ctmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_ext (
    .clk(clk), .rst(rst), .din(ext_evt), .rise(ext_rise)
  );

  for (genvar gi = 0; gi < CTMR_N_CAP; gi++) begin : g_cap
    ctmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_cap (
      .clk(clk), .rst(rst), .din(cap_trig[gi]), .rise(cap_rise[gi])
    );
    ctmr_capture #(.W(FULL_W)) u_cap (
      .clk(clk), .rst(rst), .trig(cap_rise[gi]),
      .src({cnt_hi, cnt_lo}), .val(cap_val[gi])
    );
  end

  // ---------------- prescaler ----------------
  assign cascaded = mode_q[1];
  assign pre_run  = en_lo_q && (mode_q != MODE_CASC_CNT);

  ctmr_prescaler #(.W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .run(pre_run), .clr(mode_chg),
    .reload(reload_q), .tick(tick)
  );

  // ---------------- counting control ----------------
  assign full_hit = ({cnt_hi, cnt_lo} == {mhi_q, mlo_q});
  assign casc_ev  = en_lo_q && ((mode_q == MODE_CASC_TMR) ? tick : ext_rise);

  always_comb begin
    if (cascaded) begin
      lo_step = casc_ev && !mode_chg;
      lo_wrap = full_hit;
      hi_step = lo_step && (full_hit || (cnt_lo == HALF_ONES));
      hi_wrap = full_hit;
    end else begin
      lo_step = tick && !mode_chg;
      lo_wrap = (cnt_lo == mlo_q);
      hi_step = (mode_q == MODE_MIXED) && en_hi_q && ext_rise && !mode_chg;
      hi_wrap = (cnt_hi == mhi_q);
    end
  end

  ctmr_half #(.W(HALF_W)) u_lo (
    .clk(clk), .rst(rst), .clr(mode_chg),
    .step(lo_step), .wrap(lo_wrap), .cnt(cnt_lo)
  );

  ctmr_half #(.W(HALF_W)) u_hi (
    .clk(clk), .rst(rst), .clr(mode_chg),
    .step(hi_step), .wrap(hi_wrap), .cnt(cnt_hi)
  );

  // ---------------- sticky flags ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else begin
      irq_lo <= (lo_step && lo_wrap && !cascaded) ||
                (irq_lo && !(fclr_wr && wr_data[0]));
      irq_hi <= (hi_step && hi_wrap) ||
                (irq_hi && !(fclr_wr && wr_data[1]));
    end
  end

  // ---------------- read port ----------------
  always_comb begin
    case (rd_addr)
      RA_CNT_LO:  rd_data = cnt_lo;
      RA_CNT_HI:  rd_data = cnt_hi;
      RA_CAP0_LO: rd_data = cap_val[0][HALF_W-1:0];
      RA_CAP0_HI: rd_data = cap_val[0][FULL_W-1:HALF_W];
      RA_CAP1_LO: rd_data = cap_val[1][HALF_W-1:0];
      RA_CAP1_HI: rd_data = cap_val[1][FULL_W-1:HALF_W];
      RA_FLAGS:   rd_data = {{(HALF_W-2){1'b0}}, irq_hi, irq_lo};
      RA_CTRL:    rd_data = {{(HALF_W-4){1'b0}}, en_hi_q, en_lo_q, mode_q};
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ctmr_checker.sv
module ctmr_checker #(
  parameter int HALF_W = 8,
  parameter int N_CAP  = 2
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          wr_en,
  input logic [2:0]                    wr_addr,
  input logic [HALF_W-1:0]             wr_data,
  input logic [1:0]                    mode,
  input logic [HALF_W-1:0]             cnt_lo,
  input logic [HALF_W-1:0]             cnt_hi,
  input logic                          irq_lo,
  input logic                          irq_hi,
  input logic [N_CAP-1:0]              cap_rise,
  input logic [N_CAP-1:0][2*HALF_W-1:0] cap_val
);
  logic mchg;
  assign mchg = wr_en && (wr_addr == 3'd0) && (wr_data[1:0] != mode);

  assert_flag_lo_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_lo && !(wr_en && wr_addr == 3'd4 && wr_data[0])) |=> irq_lo);

  assert_flag_hi_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_hi && !(wr_en && wr_addr == 3'd4 && wr_data[1])) |=> irq_hi);

  assert_mode_change_clears_R10: assert property (@(posedge clk) disable iff (rst)
    mchg |=> (cnt_lo == '0 && cnt_hi == '0));

  assert_split_high_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0) |-> (cnt_hi == '0));

  assert_no_lo_flag_cascade_R5: assert property (@(posedge clk) disable iff (rst)
    (mode[1] && !irq_lo) |=> !irq_lo);

  assert_lo_step_shape_R3: assert property (@(posedge clk) disable iff (rst)
    (!mode[1] && !mchg) |=>
      (cnt_lo == $past(cnt_lo)) || (cnt_lo == $past(cnt_lo) + 1'b1) || (cnt_lo == '0));

  for (genvar gi = 0; gi < N_CAP; gi++) begin : g_capchk
    assert_capture_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !cap_rise[gi] |=> $stable(cap_val[gi]));
  end
endmodule

bind capture_timer ctmr_checker #(.HALF_W(HALF_W), .N_CAP(ctmr_pkg::CTMR_N_CAP)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .mode(mode_q), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .irq_lo(irq_lo), .irq_hi(irq_hi),
  .cap_rise(cap_rise), .cap_val(cap_val)
);

// File: tb/capture_timer_test.sv
module capture_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       ext_evt = 1'b0;
  logic [1:0] cap_trig = '0;
  logic       irq_lo, irq_hi;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  capture_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_evt(ext_evt), .cap_trig(cap_trig),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic rd16(input logic [2:0] a_lo, output int v);
    int lo, hi;
    rd(a_lo, lo);
    rd(a_lo + 3'd1, hi);
    v = hi * 256 + lo;
  endtask

  // clears counts via a mode change, clears flags, loads settings
  task automatic prep(input int mode, input int rl, input int mlo, input int mhi);
    wr(3'd0, 8'(mode ^ 1));
    wr(3'd0, 8'(mode));
    wr(3'd4, 8'h03);
    wr(3'd1, 8'(rl));
    wr(3'd2, 8'(mlo));
    wr(3'd3, 8'(mhi));
  endtask

  // enable with ctrl byte, run exactly w clock edges, then disable (same mode)
  task automatic run_for(input int mode, input int ctrl, input int w);
    wr(3'd0, 8'(ctrl));
    repeat (w - 2) @(negedge clk);
    wr(3'd0, 8'(mode));
  endtask

  task automatic pulse_ext(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_evt = 1'b1;
      @(negedge clk);
      @(negedge clk); ext_evt = 1'b0;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int v, v2, c, ticks;
    int rls[4] = '{0, 1, 3, 6};
    int mts[2] = '{2, 5};
    int wls[3] = '{7, 13, 24};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state, all read addresses zero
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk($sformatf("R1 reset read addr %0d", a), v, 0);
    end
    chk("R1 reset irq_lo", int'(irq_lo), 0);
    chk("R1 reset irq_hi", int'(irq_hi), 0);

    // R2/R3: low-half timer sweep in modes 0 and 1
    for (int m = 0; m < 2; m++)
      for (int ri = 0; ri < 4; ri++)
        for (int mi = 0; mi < 2; mi++)
          for (int wi = 0; wi < 3; wi++) begin
            prep(m, rls[ri], mts[mi], 8'hFF);
            run_for(m, m | 4, wls[wi]);
            ticks = wls[wi] / (rls[ri] + 1);
            rd(3'd0, v);
            chk($sformatf("R2 R3 mode%0d P=%0d M=%0d W=%0d count", m, rls[ri], mts[mi], wls[wi]),
                v, ticks % (mts[mi] + 1));
            chk("R3 irq_lo after run", int'(irq_lo), (ticks > mts[mi]) ? 1 : 0);
            rd(3'd1, v);
            chk("R4 high half untouched by low timer", v, 0);
          end

    // R2: stopped prescaler holds count; R11 control readback
    prep(0, 2, 200, 8'hFF);
    run_for(0, 4, 9);
    repeat (10) @(negedge clk);
    rd(3'd0, v);
    chk("R2 count holds while disabled", v, 3);
    rd(3'd7, v);
    chk("R11 control readback", v, 0);
    wr(3'd0, 8'h0C);
    rd(3'd7, v);
    chk("R11 control readback with enables", v, 8'h0C);
    wr(3'd0, 8'h00);

    // R4: mode 0 ignores external events even with en_hi
    prep(0, 0, 8'hFF, 8'hFF);
    wr(3'd0, 8'h08);
    pulse_ext(5);
    rd(3'd1, v);
    chk("R4 mode0 high half stays 0", v, 0);
    chk("R4 mode0 irq_hi stays 0", int'(irq_hi), 0);

    // R4: mode 1 high half counts external edges
    prep(1, 0, 8'hFF, 2);
    wr(3'd0, 8'h09);
    pulse_ext(5);
    wr(3'd0, 8'h01);
    rd(3'd1, v);
    chk("R4 mode1 high count 5 mod 3", v, 2);
    chk("R4 mode1 irq_hi set on wrap", int'(irq_hi), 1);
    rd(3'd0, v);
    chk("R4 mode1 low half not advanced by events", v, 0);

    // R5: cascaded 16-bit timer
    prep(2, 0, 8'h02, 8'h01);
    run_for(2, 6, 300);
    rd16(3'd0, v);
    chk("R5 16-bit count 300 mod 259", v, 300 % 259);
    chk("R5 irq_hi set on 16-bit wrap", int'(irq_hi), 1);
    chk("R5 irq_lo never in cascade", int'(irq_lo), 0);

    prep(2, 0, 8'hFF, 8'hFF);
    run_for(2, 6, 700);
    rd16(3'd0, v);
    chk("R5 carry into high half count 700", v, 700);
    chk("R5 no flag before match", int'(irq_hi), 0);

    prep(2, 2, 8'hFF, 8'hFF);
    run_for(2, 6, 600);
    rd16(3'd0, v);
    chk("R5 R2 prescaled 16-bit count", v, 200);

    // R6: cascaded event counter
    prep(3, 0, 8'h04, 8'h00);
    wr(3'd0, 8'h07);
    pulse_ext(7);
    wr(3'd0, 8'h03);
    rd16(3'd0, v);
    chk("R6 16-bit events 7 mod 5", v, 2);
    chk("R6 irq_hi on event wrap", int'(irq_hi), 1);
    chk("R6 irq_lo never in cascade", int'(irq_lo), 0);

    prep(3, 0, 8'hFF, 8'hFF);
    wr(3'd0, 8'h07);
    pulse_ext(300);
    wr(3'd0, 8'h03);
    rd16(3'd0, v);
    chk("R6 300 events across halves", v, 300);

    prep(3, 0, 8'hFF, 8'hFF);
    wr(3'd0, 8'h07);
    repeat (40) @(negedge clk);
    wr(3'd0, 8'h03);
    rd16(3'd0, v);
    chk("R6 no events no count", v, 0);

    // R10: mode change clears, same mode does not
    prep(2, 0, 8'hFF, 8'hFF);
    run_for(2, 6, 10);
    wr(3'd0, 8'h02);
    rd16(3'd0, v);
    chk("R10 same-mode rewrite keeps count", v, 10);
    wr(3'd0, 8'h01);
    rd16(3'd0, v);
    chk("R10 mode change clears count", v, 0);

    // R9: flag set/clear
    prep(1, 0, 1, 0);
    run_for(1, 5, 5);
    wr(3'd0, 8'h09);
    pulse_ext(1);
    wr(3'd0, 8'h01);
    rd(3'd6, v);
    chk("R9 R11 both flags set", v, 3);
    wr(3'd4, 8'h00);
    rd(3'd6, v);
    chk("R9 writing zero keeps flags", v, 3);
    wr(3'd4, 8'h01);
    chk("R9 clear irq_lo", int'(irq_lo), 0);
    chk("R9 irq_hi kept", int'(irq_hi), 1);
    wr(3'd4, 8'h02);
    chk("R9 clear irq_hi", int'(irq_hi), 0);

    // R7/R8: capture timing while counting every cycle
    prep(2, 0, 8'hFF, 8'hFF);
    wr(3'd0, 8'h06);
    repeat (20) @(negedge clk);
    cap_trig[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd16(3'd2, v);
    chk("R8 capture read before load returns old", v, 0);
    rd16(3'd0, c);
    @(negedge clk);
    rd16(3'd2, v);
    chk("R7 R8 capture loads count at edge k+2", v, c);
    repeat (5) @(negedge clk);
    rd16(3'd2, v2);
    chk("R8 held trigger captures once", v2, v);
    cap_trig[0] = 1'b0;
    rd16(3'd4, v);
    chk("R8 capture 1 untouched", v, 0);

    wr(3'd0, 8'h02);
    rd16(3'd0, c);
    @(negedge clk); cap_trig[1] = 1'b1;
    @(negedge clk);
    @(negedge clk); cap_trig[1] = 1'b0;
    repeat (3) @(negedge clk);
    rd16(3'd4, v);
    chk("R8 capture 1 of frozen count", v, c);
    rd16(3'd2, v2);
    chk("R8 capture 0 unchanged by trigger 1", v2 == c ? 1 : 0, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule